// File: doc/BRIEF.md
# Fall-Through Dual-Clock FIFO with Level Flags

A 1024-word by 18-bit first-in first-out buffer with separate write and read clock domains. The two clocks may be unrelated, or they may be the same clock. Writes are accepted on rising edges of the load clock while the load strobe is high. Reads are accepted on rising edges of the unload clock while the unload strobe is high.

The output stage works in fall-through mode. When a word arrives in an empty buffer, that word is placed on the output and the not-empty flag rises, with no unload strobe needed. After that, each unload strobe retires the word being shown and presents the next one. Each pointer crosses into the other domain as a Gray code through two flip-flops.

Level status is computed in the write domain:
- an active-low full flag,
- a half-full flag,
- an active-low combined almost-full/almost-empty flag.

The almost threshold is set from the data bus at reset time. The output bus goes to high impedance when the output enable is low.

Top module: `ftdc_fifo`

## Requirements
- R1: While rst_ni is low, full_no=1, almost_no=1, half_o=0 and empty_no=0 (empty), and the stored word count becomes zero.
- R2: A word loaded into an empty buffer appears on rd_data_o and drives empty_no high without any unload strobe. With one shared clock, empty_no is still low after the second clock edge that follows the load edge, and is high after the third.
- R3: full_no goes low once 1024 words are stored. Load strobes while full are dropped and leave stored data unchanged. full_no returns high after words are unloaded.
- R4: Unload strobes while empty_no is low change neither the contents nor the read pointer. The next word loaded is the next word shown.
- R5: Each word after the fall-through word needs exactly one unload strobe edge to be presented, and words leave in load order.
- R6: With oe_i low, every bit of rd_data_o is high impedance. With oe_i high, rd_data_o carries the stored word uninverted.
- R7: half_o is high exactly when the write-side word count is 513 or more.
- R8: almost_no is low when the count is at most OFF or at least 1024-OFF. OFF is captured from wr_data_i[9:0] at load-clock edges while reset is held and at the first edge after its release, if prog_i is high then. Otherwise OFF is 256.
- R9: With unrelated clocks and irregular strobes on both sides, every word comes out once, in order, without loss or duplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Load clock |
| rd_clk_i | input | 1 | Unload clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Load strobe |
| wr_data_i | input | 18 | Data in; low 10 bits also give the almost offset at reset |
| prog_i | input | 1 | Offset define strobe, sampled during reset |
| rd_en_i | input | 1 | Unload strobe |
| oe_i | input | 1 | Output enable, low gives high impedance |
| rd_data_o | output | 18 | Data out, tri-stated |
| empty_no | output | 1 | Low when empty |
| full_no | output | 1 | Low when full |
| half_o | output | 1 | High at 513 words or more |
| almost_no | output | 1 | Low when near empty or near full |

## Verification
The bench targets the flag edges at 256/257, 512/513 and 767/768 words, and the programmed edges at 100/101 and 923/924.

It also covers the following failure modes:
- A design with an off-by-one threshold flips a flag one word early.
- A design that writes while full overwrites the oldest word, which the drain then reports as wrong data.
- A read pointer that moves on an empty unload strobe skips a word or shows stale data after the next load.
- A fall-through path that waits for a strobe never raises empty_no.

The unrelated-clock traffic compares every output word against a reference queue, which catches a pointer crossing that loses or repeats entries.

// File: rtl/ftdc_pkg.sv
`timescale 1ns/1ps
package ftdc_pkg;
  typedef struct packed {
    logic full_n;
    logic half;
    logic almost_n;
  } wr_flags_t;

  localparam wr_flags_t FLAGS_RST = '{full_n: 1'b1, half: 1'b0, almost_n: 1'b1};
endpackage

// File: rtl/ftdc_sync.sv
`timescale 1ns/1ps
module ftdc_sync #(
  parameter int W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s0_q, s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q <= '0;
      s1_q <= '0;
    end else begin
      s0_q <= d_i;
      s1_q <= s0_q;
    end
  end

  assign q_o = s1_q;
endmodule

// File: rtl/ftdc_ram.sv
`timescale 1ns/1ps
module ftdc_ram #(
  parameter int DW = 18,
  parameter int AW = 10
) (
  input  logic          wr_clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_clk_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // output stage is not reset
  always_ff @(posedge rd_clk_i) begin
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/ftdc_wr_side.sv
`timescale 1ns/1ps
module ftdc_wr_side
  import ftdc_pkg::*;
#(
  parameter int AW      = 10,
  parameter int DEF_OFF = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          prog_i,
  input  logic [AW-1:0] prog_val_i,
  input  logic [AW:0]   rgray_sync_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic          full_no,
  output logic          half_o,
  output logic          almost_no
);
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] DEPTH_C = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_C  = PW'(DEPTH / 2 + 1);

  logic [PW-1:0] wbin_q, wbin_n, wgray_q, rbin, cnt_n;
  logic [AW-1:0] off_q;
  logic          in_rst_q, wr_ok;
  wr_flags_t     flags_q;

  always_comb begin
    rbin[PW-1] = rgray_sync_i[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_sync_i[i];
  end

  assign wr_ok  = en_i & flags_q.full_n;
  assign wbin_n = wbin_q + PW'(wr_ok);
  assign cnt_n  = wbin_n - rbin;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q   <= '0;
      wgray_q  <= '0;
      flags_q  <= FLAGS_RST;
      in_rst_q <= 1'b1;
    end else begin
      in_rst_q         <= 1'b0;
      wbin_q           <= wbin_n;
      wgray_q          <= wbin_n ^ (wbin_n >> 1);
      flags_q.full_n   <= (cnt_n != DEPTH_C);
      flags_q.half     <= (cnt_n >= HALF_C);
      flags_q.almost_n <= !((cnt_n <= {1'b0, off_q}) ||
                            (cnt_n >= DEPTH_C - {1'b0, off_q}));
    end
  end

  // offset capture window: reset held plus first edge after release
  always_ff @(posedge clk_i) begin
    if (in_rst_q) off_q <= prog_i ? prog_val_i : AW'(DEF_OFF);
  end

  assign we_o      = wr_ok;
  assign waddr_o   = wbin_q[AW-1:0];
  assign wgray_o   = wgray_q;
  assign full_no   = flags_q.full_n;
  assign half_o    = flags_q.half;
  assign almost_no = flags_q.almost_n;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wbin_q - rbin) <= DEPTH_C); // R3
  AST_FULL_IMPLIES_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_no |-> half_o); // R7
  AST_WR_GRAY_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wgray_q ^ $past(wgray_q))); // R9
endmodule

// File: rtl/ftdc_rd_side.sv
`timescale 1ns/1ps
module ftdc_rd_side #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW:0]   wgray_sync_i,
  output logic          re_o,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic          empty_no
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin_q, rbin_n, rgray_q, wbin;
  logic          valid_q, consume, load;

  always_comb begin
    wbin[PW-1] = wgray_sync_i[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray_sync_i[i];
  end

  // slot under the output stage stays owned until retired
  assign consume = en_i & valid_q;
  assign rbin_n  = rbin_q + PW'(consume);
  assign load    = (rbin_n != wbin) & (consume | ~valid_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      valid_q <= 1'b0;
    end else begin
      rbin_q  <= rbin_n;
      rgray_q <= rbin_n ^ (rbin_n >> 1);
      valid_q <= load | (valid_q & ~consume);
    end
  end

  assign re_o     = load;
  assign raddr_o  = rbin_n[AW-1:0];
  assign rgray_o  = rgray_q;
  assign empty_no = valid_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (rbin_q != wbin)); // R4
  AST_EMPTY_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_q && (rbin_q == wbin)) |=> !valid_q || $changed(wbin) || $past(rbin_q != wbin)); // R4
  AST_RD_GRAY_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rgray_q ^ $past(rgray_q))); // R9
endmodule

// File: rtl/ftdc_fifo.sv
`timescale 1ns/1ps
module ftdc_fifo #(
  parameter int DW      = 18,
  parameter int AW      = 10,
  parameter int DEF_OFF = 256
) (
  input  logic          wr_clk_i,
  input  logic          rd_clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          prog_i,
  input  logic          rd_en_i,
  input  logic          oe_i,
  output logic [DW-1:0] rd_data_o,
  output logic          empty_no,
  output logic          full_no,
  output logic          half_o,
  output logic          almost_no
);
  localparam int PW = AW + 1;

  logic          we, re;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [DW-1:0] q;

  ftdc_wr_side #(.AW(AW), .DEF_OFF(DEF_OFF)) u_wr (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .en_i(wr_en_i), .prog_i(prog_i),
    .prog_val_i(wr_data_i[AW-1:0]), .rgray_sync_i(rgray_s),
    .we_o(we), .waddr_o(waddr), .wgray_o(wgray),
    .full_no(full_no), .half_o(half_o), .almost_no(almost_no)
  );

  ftdc_rd_side #(.AW(AW)) u_rd (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .en_i(rd_en_i), .wgray_sync_i(wgray_s),
    .re_o(re), .raddr_o(raddr), .rgray_o(rgray), .empty_no(empty_no)
  );

  ftdc_sync #(.W(PW)) u_sync_w2r (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .d_i(wgray), .q_o(wgray_s)
  );

  ftdc_sync #(.W(PW)) u_sync_r2w (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rgray_s)
  );

  ftdc_ram #(.DW(DW), .AW(AW)) u_ram (
    .wr_clk_i(wr_clk_i), .we_i(we), .waddr_i(waddr), .wdata_i(wr_data_i),
    .rd_clk_i(rd_clk_i), .re_i(re), .raddr_i(raddr), .rdata_o(q)
  );

  assign rd_data_o = oe_i ? q : {DW{1'bz}};
endmodule

// File: tb/ftdc_fifo_tb_top.sv
`timescale 1ns/1ps
module ftdc_fifo_tb_top;
  localparam int DW = 18;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;
  localparam int NV = 9;
  // {count, expected half_o, expected almost_no} at default offset 256
  localparam logic [12:0] FILL_VEC [NV] = '{
    {11'd1,    1'b0, 1'b0}, {11'd256,  1'b0, 1'b0}, {11'd257,  1'b0, 1'b1},
    {11'd512,  1'b0, 1'b1}, {11'd513,  1'b1, 1'b1}, {11'd767,  1'b1, 1'b1},
    {11'd768,  1'b1, 1'b0}, {11'd1023, 1'b1, 1'b0}, {11'd1024, 1'b1, 1'b0}
  };

  logic clk = 1'b0, aclk = 1'b0, async_mode = 1'b0;
  logic rd_clk;
  logic rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, prog = 1'b0, oe = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic empty_no, full_no, half_o, almost_no;
  int checks = 0, fails = 0, written = 0;
  logic [DW-1:0] ref_q [$];

  always #2 clk = ~clk;
  always #3 aclk = ~aclk;
  assign rd_clk = async_mode ? aclk : clk;

  ftdc_fifo dut_i (
    .wr_clk_i(clk), .rd_clk_i(rd_clk), .rst_ni(rst_n), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .prog_i(prog), .rd_en_i(rd_en), .oe_i(oe),
    .rd_data_o(rd_data), .empty_no(empty_no), .full_no(full_no),
    .half_o(half_o), .almost_no(almost_no)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return DW'((i * 613) ^ 32'h2C5A9);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic do_reset(input logic p, input logic [DW-1:0] v);
    @(negedge clk);
    rst_n = 1'b0; prog = p; wr_data = v; wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "full_no", 32'(full_no), 32'd1);
    chk("R1", "almost_no", 32'(almost_no), 32'd1);
    chk("R1", "half_o", 32'(half_o), 32'd0);
    chk("R1", "empty_no", 32'(empty_no), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    prog = 1'b0;
    @(negedge clk);
    written = 0;
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop(input logic [DW-1:0] exp, input string req);
    int n = 0;
    @(negedge rd_clk);
    while (!empty_no && n < 2000) begin
      @(negedge rd_clk);
      n++;
    end
    chk(req, "empty_no", 32'(empty_no), 32'd1);
    chk(req, "rd_data_o", 32'(rd_data), 32'(exp));
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
  endtask

  task automatic fill_to(input int n);
    while (written < n) begin
      push(pat(written));
      written++;
    end
  endtask

  initial begin
    #(150000 * 4);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    do_reset(1'b0, '0);

    // R2: fall-through timing with one shared clock
    push(pat(0));
    written = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R2", "empty_no after 2 edges", 32'(empty_no), 32'd0);
    @(negedge clk);
    chk("R2", "empty_no after 3 edges", 32'(empty_no), 32'd1);
    chk("R2", "fall-through data", 32'(rd_data), 32'(pat(0)));

    // R6: output enable
    oe = 1'b0;
    #1;
    checks++;
    if (rd_data !== {DW{1'bz}}) begin
      fails++;
      $display("FAIL R6 rd_data_o actual=%b expected=all z", rd_data);
    end
    oe = 1'b1;
    #1;
    chk("R6", "enabled data", 32'(rd_data), 32'(pat(0)));

    // R7 / R8: walk the flag vector table at default offset
    for (int i = 0; i < NV; i++) begin
      fill_to(int'(FILL_VEC[i][12:2]));
      chk("R7", $sformatf("half_o at %0d", written), 32'(half_o), 32'(FILL_VEC[i][1]));
      chk("R8", $sformatf("almost_no at %0d", written), 32'(almost_no), 32'(FILL_VEC[i][0]));
    end

    // R3: full, loads dropped
    chk("R3", "full_no at 1024", 32'(full_no), 32'd0);
    for (int k = 0; k < 5; k++) push({DW{1'b1}});
    chk("R3", "full_no after dropped loads", 32'(full_no), 32'd0);

    // R5: drain in order, one strobe per word
    for (int i = 0; i < DEPTH; i++) pop(pat(i), "R5");
    repeat (4) @(negedge clk);
    chk("R5", "empty_no after drain", 32'(empty_no), 32'd0);
    chk("R3", "full_no after drain", 32'(full_no), 32'd1);

    // R4: unload while empty ignored
    rd_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R4", "empty_no during empty unload", 32'(empty_no), 32'd0);
    end
    rd_en = 1'b0;
    push(pat(5000));
    pop(pat(5000), "R4");
    push(pat(5001));
    push(pat(5002));
    pop(pat(5001), "R4");
    pop(pat(5002), "R5");

    // R8: programmed offset 100
    do_reset(1'b1, DW'(100));
    fill_to(100);
    chk("R8", "almost_no at 100 off100", 32'(almost_no), 32'd0);
    fill_to(101);
    chk("R8", "almost_no at 101 off100", 32'(almost_no), 32'd1);
    fill_to(923);
    chk("R8", "almost_no at 923 off100", 32'(almost_no), 32'd1);
    fill_to(924);
    chk("R8", "almost_no at 924 off100", 32'(almost_no), 32'd0);

    // R9: unrelated clocks against a reference queue
    async_mode = 1'b1;
    do_reset(1'b0, '0);
    fork
      begin
        for (int i = 0; i < 300; i++) begin
          @(negedge clk);
          while (!full_no) @(negedge clk);
          wr_en = 1'b1; wr_data = pat(i + 7000);
          ref_q.push_back(pat(i + 7000));
          @(negedge clk);
          wr_en = 1'b0;
          repeat ($urandom_range(0, 3)) @(negedge clk);
        end
      end
      begin
        for (int i = 0; i < 300; i++) begin
          int n = 0;
          logic [DW-1:0] exp;
          @(negedge rd_clk);
          while (!empty_no && n < 2000) begin
            @(negedge rd_clk);
            n++;
          end
          if (ref_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R9 word %0d actual=present expected=none", i);
          end else begin
            exp = ref_q.pop_front();
            chk("R9", $sformatf("async word %0d", i), 32'(rd_data), 32'(exp));
          end
          rd_en = 1'b1;
          @(negedge rd_clk);
          rd_en = 1'b0;
          repeat ($urandom_range(0, 4)) @(negedge rd_clk);
        end
      end
    join
    repeat (6) @(negedge rd_clk);
    chk("R9", "empty after traffic", 32'(empty_no), 32'd0);

    report();
    $finish;
  end
endmodule